// File: doc/BRIEF.md
# DMA Request Sense and Acknowledge Unit

This unit sits between an external DMA request pin and the transfer engine of a DMA channel. It brings the asynchronous request into the clock domain, recognises a request either on a transition to the active level or while the input rests at the active level, and issues a one-cycle trigger to the transfer engine. While a transfer runs, the unit drives an acknowledge output. The engine reports the end of the transfer on a done input.

The unit checks that the selected sense style suits the selected transfer mode. Transition sensing cannot be combined with continuous transfer. That pairing raises a configuration error and produces no triggers. The request input is ignored while a transfer is outstanding. The acknowledge is held for a minimum width. With transition sensing, it also stays low for a minimum interval before it may rise again. In continuous mode with level sensing, the engine is asked to pause whenever the request drops away, and to resume when it returns.

Top module: `dma_req_sense`

## Requirements
- R1: While `rst_n` is low at a clock edge, `trig`, `ack_out` and `pause` are 0 after that edge.
- R2: With level sensing (`cfg_edge`=0), an idle unit whose request input is at the active level gives `trig`=1 and `ack_out`=1 after the third rising clock edge that follows the input change (two synchroniser stages plus one sequencer register).
- R3: With transition sensing (`cfg_edge`=1), only a change to the active level starts a transfer. A request held steadily at the active level never starts a second transfer.
- R4: `cfg_active_low`=0 makes high (or rising) active. `cfg_active_low`=1 makes low (or falling) active.
- R5: `ack_out` stays high for at least `ACK_MIN` (default 2) cycles even when `xfer_done` arrives in its first cycle. Otherwise it falls after the first clock edge that samples `xfer_done`=1.
- R6: With transition sensing, `ack_out` stays low for at least `GAP_MIN` (default 2) cycles between transfers. A transition that arrives while `ack_out` is high, or during that low interval, is discarded.
- R7: While a transfer is outstanding, the request input starts no further transfer. With level sensing, a request still active after the transfer ends starts a new transfer one cycle after `ack_out` falls.
- R8: `cfg_mode` is encoded as 0 single step, 1 block step, 2 continuous, 3 burst. `cfg_err` is 1 exactly for `cfg_edge`=1 with `cfg_mode`=2 (registered, one cycle after the configuration). That pairing never produces `trig`. All seven other pairings give `cfg_err`=0.
- R9: With `cfg_edge`=0 and `cfg_mode`=2, `pause` is 1 while `ack_out` is high and the synchronised request is inactive, and 0 otherwise.
- R10: `trig` is one cycle wide, and one request gives exactly one trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_in | input | 1 | Asynchronous external DMA request |
| cfg_edge | input | 1 | 1 = transition sensing, 0 = level sensing |
| cfg_active_low | input | 1 | 1 = low/falling active, 0 = high/rising active |
| cfg_mode | input | 2 | Transfer mode: 0 single, 1 block, 2 continuous, 3 burst |
| xfer_done | input | 1 | Transfer engine reports the end of the transfer |
| trig | output | 1 | One-cycle start pulse to the transfer engine |
| ack_out | output | 1 | External DMA acknowledge |
| pause | output | 1 | Asks the engine to hold a continuous transfer |
| cfg_err | output | 1 | Illegal sense/mode pairing selected |

## Verification
The hardest case to reach is a request transition that lands inside the enforced low interval of the acknowledge. The transition must pass the synchroniser exactly while the sequencer has already dropped the acknowledge but has not yet returned to idle. The bench reaches this case by counting cycles from the trigger. It raises `xfer_done` and the request on the same falling edge, so that the synchronised transition arrives two edges later, in the middle of the low interval. It then confirms that no trigger follows. A sweep over all sixteen pairings of sense style, polarity and transfer mode covers legality and polarity.

// File: rtl/dma_rs_pkg.sv
// Package: shared types for the DMA request sense unit.
// Assumes: transfer mode encoding is fixed at 0 single, 1 block,
// 2 continuous, 3 burst.
package dma_rs_pkg;

    typedef enum logic [1:0] {
        XM_SINGLE = 2'd0,
        XM_BLOCK  = 2'd1,
        XM_CONT   = 2'd2,
        XM_BURST  = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_BUSY = 2'd1,
        SQ_GAP  = 2'd2
    } seq_state_e;

    // Transition sensing is not allowed with continuous transfer.
    function automatic logic combo_legal(input logic edge_mode, input xfer_mode_e mode);
        return !(edge_mode && (mode == XM_CONT));
    endfunction

endpackage

// File: rtl/rs_sync.sv
// Module: rs_sync
// Brings an asynchronous input into the clock domain through STAGES flops.
// Assumes: STAGES >= 2. The reset value is supplied as an input, so that
// the chain can settle at the inactive level for the selected polarity.
module rs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_val,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] pipe;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage captures the raw pin.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[0] <= rst_val;
                else        pipe[0] <= d;
            end
        end else begin : g_rest
            // Later stages resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[i] <= rst_val;
                else        pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/rs_detect.sv
// Module: rs_detect
// Applies polarity to the synchronised request and produces either a
// transition hit or a level hit. It also decides whether the configured
// sense/mode pairing is legal.
// Assumes: the configuration is static while a transfer is outstanding.
module rs_detect
    import dma_rs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_sync,
    input  logic       active_low,
    input  logic       edge_mode,
    input  xfer_mode_e mode,
    output logic       req_act,
    output logic       req_hit,
    output logic       legal
);

    logic act_q;

    assign req_act = req_sync ^ active_low;
    assign legal   = combo_legal(edge_mode, mode);

    // Remembers the previous active state for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= req_act;
    end

    // Chooses the recognition rule and blocks illegal pairings.
    always_comb begin
        if (!legal)         req_hit = 1'b0;
        else if (edge_mode) req_hit = req_act && !act_q;
        else                req_hit = req_act;
    end

    // R3: in transition mode a hit cannot persist into a second cycle.
    a_r3_edge_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && req_hit) |=> !(edge_mode && req_hit));

endmodule

// File: rtl/rs_ack_seq.sv
// Module: rs_ack_seq
// Sequencer: issues the trigger, holds the acknowledge for a minimum
// width and until the engine reports done, and enforces a minimum low
// interval in transition mode. Requests are only accepted in idle.
// Assumes: ACK_MIN >= 2 and GAP_MIN >= 2; xfer_done may pulse at any
// time after trig and is remembered until the minimum width has passed.
module rs_ack_seq
    import dma_rs_pkg::*;
#(
    parameter int ACK_MIN = 2,
    parameter int GAP_MIN = 2,
    parameter int CNT_W   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_hit,
    input  logic req_act,
    input  logic edge_mode,
    input  logic cont_level,
    input  logic xfer_done,
    output logic trig_o,
    output logic ack_o,
    output logic pause_o
);

    localparam logic [CNT_W-1:0] ACK_LAST = CNT_W'(ACK_MIN - 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_MIN - 1);

    seq_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic             done_seen;
    logic             done_now;

    assign done_now = done_seen || xfer_done;

    // Main sequencer: state, width counter, trigger and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SQ_IDLE;
            cnt       <= '0;
            done_seen <= 1'b0;
            trig_o    <= 1'b0;
            ack_o     <= 1'b0;
        end else begin
            trig_o <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (req_hit) begin
                        st        <= SQ_BUSY;
                        cnt       <= '0;
                        done_seen <= 1'b0;
                        trig_o    <= 1'b1;
                        ack_o     <= 1'b1;
                    end
                end
                SQ_BUSY: begin
                    if (done_now && (cnt >= ACK_LAST)) begin
                        ack_o     <= 1'b0;
                        cnt       <= '0;
                        done_seen <= 1'b0;
                        st        <= edge_mode ? SQ_GAP : SQ_IDLE;
                    end else begin
                        done_seen <= done_now;
                        if (cnt < ACK_LAST) cnt <= cnt + 1'b1;
                    end
                end
                SQ_GAP: begin
                    if (cnt >= GAP_LAST) st <= SQ_IDLE;
                    else                 cnt <= cnt + 1'b1;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // Pause request while a continuous level transfer loses its request.
    assign pause_o = cont_level && (st == SQ_BUSY) && !req_act;

    // R5: a falling acknowledge was high for at least two cycles.
    a_r5_ack_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_o) |-> $past(ack_o, 2));

    // R6: in transition mode a rising acknowledge was low for two cycles.
    a_r6_edge_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && $rose(ack_o)) |-> !$past(ack_o, 2));

    // R7: a trigger only comes with a fresh acknowledge.
    a_r7_trig_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> $rose(ack_o));

    // R10: the trigger is a single-cycle pulse.
    a_r10_trig_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    // R9: a pause request only exists during a transfer.
    a_r9_pause_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        pause_o |-> ack_o);

endmodule

// File: rtl/dma_req_sense.sv
// Module: dma_req_sense (top)
// DMA request sense and acknowledge unit: synchroniser, detector and
// acknowledge sequencer. It also registers the configuration legality
// flag.
// Assumes: cfg_* inputs change only while idle or under reset.
module dma_req_sense
    import dma_rs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ACK_MIN     = 2,
    parameter int GAP_MIN     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_in,
    input  logic       cfg_edge,
    input  logic       cfg_active_low,
    input  logic [1:0] cfg_mode,
    input  logic       xfer_done,
    output logic       trig,
    output logic       ack_out,
    output logic       pause,
    output logic       cfg_err
);

    localparam int CNT_MAX = (ACK_MIN > GAP_MIN) ? ACK_MIN : GAP_MIN;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    xfer_mode_e mode;
    logic       req_sync;
    logic       req_act;
    logic       req_hit;
    logic       legal;
    logic       cont_level;

    assign mode       = xfer_mode_e'(cfg_mode);
    assign cont_level = !cfg_edge && (mode == XM_CONT);

    rs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val (cfg_active_low),
        .d       (req_in),
        .q       (req_sync)
    );

    rs_detect u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_sync   (req_sync),
        .active_low (cfg_active_low),
        .edge_mode  (cfg_edge),
        .mode       (mode),
        .req_act    (req_act),
        .req_hit    (req_hit),
        .legal      (legal)
    );

    rs_ack_seq #(
        .ACK_MIN (ACK_MIN),
        .GAP_MIN (GAP_MIN),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_hit    (req_hit),
        .req_act    (req_act),
        .edge_mode  (cfg_edge),
        .cont_level (cont_level),
        .xfer_done  (xfer_done),
        .trig_o     (trig),
        .ack_o      (ack_out),
        .pause_o    (pause)
    );

    // Registers the configuration error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= !legal;
    end

    // R8: an illegal pairing flagged last cycle produces no trigger now.
    a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !trig);

    // R1: outputs are quiet in the first cycle after reset.
    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (!trig && !ack_out && !pause));

endmodule

// File: tb/dma_req_sense_test.sv
module dma_req_sense_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_in = 1'b0;
    logic       cfg_edge = 1'b0;
    logic       cfg_active_low = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic       xfer_done = 1'b0;
    logic       trig, ack_out, pause, cfg_err;

    int n_chk = 0;
    int n_fail = 0;
    int trig_seen = 0;
    int hi_run = 0;
    int lo_run = 0;
    bit seen_ack = 0;
    bit prev_ack = 0;
    bit finished = 0;

    dma_req_sense uut (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .cfg_edge(cfg_edge),
        .cfg_active_low(cfg_active_low), .cfg_mode(cfg_mode),
        .xfer_done(xfer_done), .trig(trig), .ack_out(ack_out),
        .pause(pause), .cfg_err(cfg_err)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drives the raw pin to the active or inactive level.
    task automatic drive(input bit active);
        req_in = active ? ~cfg_active_low : cfg_active_low;
    endtask

    task automatic do_reset(input bit e, input bit pol, input int m);
        @(negedge clk);
        rst_n = 1'b0; cfg_edge = e; cfg_active_low = pol;
        cfg_mode = 2'(m); xfer_done = 1'b0; drive(0);
        tick(3);
        check("R1 reset outputs", {trig, ack_out, pause}, 0);
        rst_n = 1'b1;
        tick(2);
    endtask

    // Monitor away from the edge: trigger count and acknowledge run lengths.
    always @(posedge clk) begin
        #2;
        if (!rst_n) begin
            seen_ack = 0; prev_ack = 0; hi_run = 0; lo_run = 0;
        end else begin
            if (trig) trig_seen++;
            if (ack_out && !prev_ack && seen_ack && cfg_edge)
                check("R6 ack low interval", int'(lo_run >= 2), 1);
            if (!ack_out && prev_ack)
                check("R5 ack high width", int'(hi_run >= 2), 1);
            if (ack_out) begin
                hi_run = prev_ack ? hi_run + 1 : 1;
                seen_ack = 1;
            end else begin
                lo_run = prev_ack ? 1 : lo_run + 1;
            end
            prev_ack = ack_out;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int snap;
        // Sweep: sense style x polarity x transfer mode (R2, R3, R4, R8, R10).
        for (int e = 0; e < 2; e++) begin
            for (int p = 0; p < 2; p++) begin
                for (int m = 0; m < 4; m++) begin
                    int ok;
                    ok = (e == 1 && m == 2) ? 0 : 1;
                    do_reset(e[0], p[0], m);
                    check("R8 cfg_err", cfg_err, 1 - ok);
                    snap = trig_seen;
                    drive(1);
                    tick(3);
                    check(e ? "R3 R4 edge trig" : "R2 R4 level trig", trig, ok);
                    xfer_done = 1'b1; drive(0);
                    tick(1);
                    xfer_done = 1'b0;
                    tick(12);
                    check("R10 one trigger per request", trig_seen - snap, ok);
                    check("R8 ack idle after sweep", ack_out, 0);
                end
            end
        end

        // R5: immediate done still gives two cycles of acknowledge.
        do_reset(0, 0, 0);
        drive(1); tick(3);
        check("R2 level trig", trig, 1);
        xfer_done = 1'b1; drive(0); tick(1);
        check("R5 ack held cycle 2", ack_out, 1);
        xfer_done = 1'b0; tick(1);
        check("R5 ack released", ack_out, 0);

        // R5: acknowledge waits for a late done.
        do_reset(0, 0, 1);
        drive(1); tick(3); drive(0); tick(5);
        check("R5 ack waits for done", ack_out, 1);
        xfer_done = 1'b1; tick(1);
        check("R5 ack falls after done", ack_out, 0);
        xfer_done = 1'b0; tick(4);

        // R7: level request masked while busy, retrigger after done.
        do_reset(0, 0, 0);
        snap = trig_seen;
        drive(1); tick(3); drive(0); tick(3); drive(1); tick(6);
        check("R7 masked while busy", trig_seen - snap, 1);
        check("R7 ack still high", ack_out, 1);
        xfer_done = 1'b1; tick(1);
        xfer_done = 1'b0;
        check("R7 ack fell", ack_out, 0);
        tick(1);
        check("R7 retrigger on held level", trig, 1);
        xfer_done = 1'b1; drive(0); tick(1); xfer_done = 1'b0; tick(8);

        // R9: pause follows the request in continuous level mode.
        do_reset(0, 0, 2);
        drive(1); tick(3); drive(0); tick(1);
        check("R9 pause not yet", pause, 0);
        tick(1);
        check("R9 pause on drop", pause, 1);
        drive(1); tick(1);
        check("R9 pause holds", pause, 1);
        tick(1);
        check("R9 pause released", pause, 0);
        check("R9 ack during pause run", ack_out, 1);
        xfer_done = 1'b1; drive(0); tick(1); xfer_done = 1'b0; tick(8);

        // R6, R3: transitions during busy and low interval are discarded.
        do_reset(1, 1, 3);
        snap = trig_seen;
        drive(1); tick(3);
        check("R3 falling edge trig active-low", trig, 1);
        tick(1); drive(0); tick(1); drive(1); tick(1); drive(0); tick(2);
        xfer_done = 1'b1; drive(1); tick(1);
        xfer_done = 1'b0;
        check("R6 ack low after done", ack_out, 0);
        tick(11);
        check("R6 R3 no trigger in gap or on held level", trig_seen - snap, 1);
        drive(0); tick(3); drive(1); tick(3);
        check("R3 fresh edge after gap", trig, 1);
        xfer_done = 1'b1; drive(0); tick(1); xfer_done = 1'b0; tick(8);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule